// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR flash and waits for an embedded program or erase operation to finish. After the host logic has written the command sequence itself, it pulses `start_i` together with a polling address and the datum it expects to find there. The poller then issues read cycles to that address and watches the top data bit and the timeout-flag bit (bit 5) until it can give a verdict.

The polling address must be one where status is valid. For a program, that is the programmed location. For a sector erase, it is any location inside a sector being erased. For a whole-chip erase, it is any location in an unprotected sector. For an erase, the caller passes an expected byte whose top bit is 1, for example 0xFF.

If the top bit already matches on the first read, bit 5 plays no part. The flash may update the top bit in the same cycle as the timeout flag, so a set timeout flag always triggers one further read before any failure is declared. A pass also costs one extra read, because the low bits may still have been changing when the top bit flipped. `result_o` therefore always holds a byte taken from a fresh read.

States: `S_IDLE` (waiting for a start) → `S_POLL` (status read). From `S_POLL`: → `S_VERIFY` when the top bit matches; → `S_RECHECK` when it mismatches and the timeout flag is set; → `S_POLL` when it mismatches and the flag is clear. From `S_RECHECK`: → `S_VERIFY` on a match; → `S_DONE` (fail) on a mismatch. `S_VERIFY` (data read) → `S_DONE` (pass). `S_DONE` → `S_IDLE` after one cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`, `done_o`, `pass_o`, `fail_o` and `mem_oe_o` are 0.
- R2: A start accepted in idle latches `poll_addr_i` and `expect_i`. `mem_addr_o` shows the latched address from the cycle after the start until the run ends.
- R3: Each read cycle lasts RD_CYC+1 clocks: one setup clock with `mem_oe_o` low, then RD_CYC clocks with `mem_oe_o` high. `mem_rdata_i` is sampled on the last high clock.
- R4: When bit 7 of a status read equals bit 7 of the expected byte, exactly one more read is issued. The run then passes, and `result_o` holds the byte from that extra read.
- R5: When bit 7 mismatches and bit 5 is 0, another status read to the same address follows.
- R6: When bit 7 mismatches and bit 5 is 1, exactly one recheck read follows. If its bit 7 matches, the R4 extra read and a pass follow. If it mismatches, the run fails with no further read, and `result_o` holds the recheck byte.
- R7: Bit 5 is ignored on any read whose bit 7 matches.
- R8: `done_o` is high for exactly one clock at the end of a run. `pass_o` and `fail_o` are never both 1. Both are cleared when the next start is accepted and otherwise hold their value.
- R9: A start pulse while `busy_o` is 1 has no effect on the address, the expected byte or the sequence of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| poll_addr_i | input | AW | Valid polling address |
| expect_i | input | DW | Expected datum (top bit 1 for an erase) |
| mem_rdata_i | input | DW | Flash read data bus |
| mem_addr_o | output | AW | Flash address bus |
| mem_oe_o | output | 1 | Flash output enable, active high |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run ended with a match |
| fail_o | output | 1 | Run ended with a timeout and mismatch |
| result_o | output | DW | Byte from the final read of the run |

## Verification
The responses returned to successive reads are scripted so that each path can be told apart by its read count and final byte:
- A match on the first read.
- Several clear-flag mismatches before a match.
- A set flag followed by a match, and a set flag followed by a mismatch.
- A set flag arriving after clear-flag polling.
- A matching read that also carries a set flag, which must still pass (R7).

The verify byte differs from the matching status byte in several vectors, which proves that `result_o` comes from the extra read. Directed tests cover the reset state, a start injected mid-run with a different address and expected byte, and the one-cycle width of `done_o`. The number of enable-high clocks in every read is also measured.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_POLL    = 3'd1,
        S_RECHECK = 3'd2,
        S_VERIFY  = 3'd3,
        S_DONE    = 3'd4
    } poll_state_t;

endpackage

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int RD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic oe_o,
    output logic last_o
);
    localparam int CW = $clog2(RD_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign oe_o   = run_i && (cnt_q != '0);
    assign last_o = run_i && (cnt_q == CW'(RD_CYC));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(RD_CYC)); // R3

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
    parameter int DW      = 8,
    parameter int TMO_BIT = 5
) (
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] expect_i,
    output logic          top_match_o,
    output logic          tmo_set_o
);
    localparam int TOP_BIT = DW - 1;

    assign top_match_o = (rdata_i[TOP_BIT] == expect_i[TOP_BIT]);
    assign tmo_set_o   = rdata_i[TMO_BIT];

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int RD_CYC  = 3,
    parameter int TMO_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] poll_addr_i,
    input  logic [DW-1:0] expect_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_oe_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [DW-1:0] result_o
);
    poll_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          reading;
    logic          rd_last;
    logic          top_ok;
    logic          tmo_set;
    logic          accept;

    assign reading = (state_q == S_POLL) || (state_q == S_RECHECK) ||
                     (state_q == S_VERIFY);
    assign accept  = (state_q == S_IDLE) && start_i;

    flash_poll_timer #(.RD_CYC(RD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (reading),
        .oe_o   (mem_oe_o),
        .last_o (rd_last)
    );

    flash_poll_eval #(.DW(DW), .TMO_BIT(TMO_BIT)) u_eval (
        .rdata_i     (mem_rdata_i),
        .expect_i    (exp_q),
        .top_match_o (top_ok),
        .tmo_set_o   (tmo_set)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_POLL;
            end
            S_POLL: begin
                if (rd_last) begin
                    if (top_ok)       state_d = S_VERIFY;
                    else if (tmo_set) state_d = S_RECHECK;
                    else              state_d = S_POLL;
                end
            end
            S_RECHECK: begin
                if (rd_last) state_d = top_ok ? S_VERIFY : S_DONE;
            end
            S_VERIFY: begin
                if (rd_last) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Registered outputs and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            exp_q    <= '0;
            pass_o   <= 1'b0;
            fail_o   <= 1'b0;
            result_o <= '0;
        end else begin
            if (accept) begin
                addr_q <= poll_addr_i;
                exp_q  <= expect_i;
                pass_o <= 1'b0;
                fail_o <= 1'b0;
            end
            if (rd_last && (state_q == S_RECHECK) && !top_ok) begin
                fail_o   <= 1'b1;
                result_o <= mem_rdata_i;
            end
            if (rd_last && (state_q == S_VERIFY)) begin
                pass_o   <= 1'b1;
                result_o <= mem_rdata_i;
            end
        end
    end

    assign mem_addr_o = addr_q;
    assign busy_o     = (state_q != S_IDLE);
    assign done_o     = (state_q == S_DONE);

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R2
    AST_SAMPLE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> mem_oe_o); // R3
    AST_FAIL_FROM_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(state_q == S_RECHECK)); // R6
    AST_PASS_FROM_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> $past(state_q == S_VERIFY)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o)); // R8
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_o) |-> (done_o || $past(start_i && !busy_o))); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i && busy_o) && busy_o) |-> $stable(mem_addr_o)); // R9

endmodule

// File: tb/flash_poll_ctrl_tb_top.sv
module flash_poll_ctrl_tb_top;
    localparam int AW     = 17;
    localparam int DW     = 8;
    localparam int RD_CYC = 3;

    typedef struct packed {
        logic [7:0] exp;
        logic [7:0] r0;
        logic [7:0] r1;
        logic [7:0] r2;
        logic [7:0] r3;
        logic       pass;
        logic [3:0] nrd;
        logic [7:0] dout;
    } vec_t;

    // expected, four scripted reads (last repeats), verdict, read count, result
    localparam vec_t VECS [7] = '{
        '{8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 1'b1, 4'd2, 8'h5A}, // R4
        '{8'hA5, 8'h05, 8'h05, 8'hA5, 8'hA5, 1'b1, 4'd4, 8'hA5}, // R5
        '{8'hFF, 8'h20, 8'hFF, 8'hFF, 8'hFF, 1'b1, 4'd3, 8'hFF}, // R6 match
        '{8'hFF, 8'h20, 8'h20, 8'h00, 8'h00, 1'b0, 4'd2, 8'h20}, // R6 fail
        '{8'h33, 8'hB3, 8'h33, 8'h35, 8'h35, 1'b1, 4'd3, 8'h35}, // R6/R4
        '{8'hFF, 8'hA0, 8'h7F, 8'h7F, 8'h7F, 1'b1, 4'd2, 8'h7F}, // R7
        '{8'h12, 8'h92, 8'hB2, 8'h12, 8'h12, 1'b1, 4'd4, 8'h12}  // R5/R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] poll_addr_i = '0;
    logic [DW-1:0] expect_i = '0;
    logic [DW-1:0] mem_rdata_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_oe_o;
    logic          busy_o, done_o, pass_o, fail_o;
    logic [DW-1:0] result_o;

    int n_cmp = 0;
    int n_mis = 0;
    int rd_idx = 0;
    int hi_len = 0;
    logic oe_d = 1'b0;
    logic finished = 1'b0;
    logic [7:0] rsp [4];

    always #4 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .poll_addr_i(poll_addr_i), .expect_i(expect_i),
        .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
        .mem_oe_o(mem_oe_o), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .result_o(result_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flash model: a new scripted byte on each rising enable; enable width check
    always @(negedge clk) begin
        if (mem_oe_o && !oe_d) begin
            mem_rdata_i = rsp[(rd_idx < 4) ? rd_idx : 3];
            rd_idx = rd_idx + 1;
        end
        if (mem_oe_o) begin
            hi_len = hi_len + 1;
        end else if (oe_d) begin
            chk("R3 enable-high clocks", hi_len, RD_CYC);
            hi_len = 0;
        end
        oe_d = mem_oe_o;
    end

    task automatic launch(input logic [AW-1:0] a, input logic [7:0] e);
        @(negedge clk);
        rd_idx = 0;
        start_i = 1'b1;
        poll_addr_i = a;
        expect_i = e;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", busy_o, 1);
        chk("R3 setup clock enable low", mem_oe_o, 0);
        chk("R2 address driven", mem_addr_o, a);
        chk("R8 verdict cleared on start", {pass_o, fail_o}, 0);
    endtask

    task automatic await_done(input string req, input logic pass, input int nrd,
                              input logic [7:0] dout);
        int cyc = 0;
        while (!done_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " done seen"}, done_o, 1);
        chk({req, " pass"}, pass_o, pass);
        chk({req, " fail"}, fail_o, !pass);
        chk({req, " read count"}, rd_idx, nrd);
        chk({req, " result byte"}, result_o, dout);
        @(negedge clk);
        chk("R8 done one clock", done_o, 0);
        chk("R8 verdict held", {pass_o, fail_o}, {pass, !pass});
    endtask

    initial begin
        rsp[0] = 8'h00; rsp[1] = 8'h00; rsp[2] = 8'h00; rsp[3] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {busy_o, done_o, pass_o, fail_o, mem_oe_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {busy_o, done_o, pass_o, fail_o, mem_oe_o}, 0);

        for (int i = 0; i < 7; i++) begin
            rsp[0] = VECS[i].r0; rsp[1] = VECS[i].r1;
            rsp[2] = VECS[i].r2; rsp[3] = VECS[i].r3;
            launch(AW'(32'h100 + i), VECS[i].exp);
            await_done("R4/R5/R6/R7 vector", VECS[i].pass, int'(VECS[i].nrd), VECS[i].dout);
        end

        // R9: start while busy must be ignored
        rsp[0] = 8'h05; rsp[1] = 8'h05; rsp[2] = 8'h05; rsp[3] = 8'hA5;
        launch(AW'(32'h00ABC), 8'hA5);
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        poll_addr_i = AW'(32'h1FFFF);
        expect_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R9 address kept", mem_addr_o, AW'(32'h00ABC));
        await_done("R9 run unchanged", 1'b1, 5, 8'hA5);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

endmodule